// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between one processor and a shared memory port in a system that keeps total store order. Stores and swaps from the processor are written into a small circular queue in issue order. The queue drains toward memory one entry at a time through a request/grant handshake. Memory therefore sees this processor's writes in exactly program order. The order across processors is set by whichever processor the external arbiter grants.

Every load is compared against all valid queue entries. When one or more entries hold the same address, the load takes the data of the youngest of them and completes on the next cycle. When nothing matches, the load goes straight to memory and completes when memory answers.

A swap travels through the queue like a store. Its old value comes back only after memory has performed it. While a load or swap is outstanding, the processor port refuses further operations.

Top module: `store_fwd_buffer`

## Requirements
- R1: While reset is held and on the first cycle after it, the queue is empty. `mem_req`, `mem_ld_valid` and `cpu_rvalid` are low, and `cpu_ready` is high.
- R2: `cpu_op` encodes 00 as load, 10 as swap, and 01 or 11 as store. A store or swap is accepted (`cpu_valid && cpu_ready`) in the cycle it is presented whenever fewer than DEPTH entries are held. With DEPTH entries held and no operation in flight, `cpu_ready` is low for stores and swaps but stays high for loads.
- R3: `mem_req` is high exactly when the queue holds an entry. `mem_addr`, `mem_wdata` and `mem_swap` show the oldest entry. That entry leaves in the cycle `mem_gnt` is high. Entries reach memory strictly in acceptance order.
- R4: An accepted load whose address matches a queued entry raises no memory read. In the following cycle it returns the data of the youngest matching entry on `cpu_rdata`, with `cpu_rvalid` high.
- R5: The entry being granted in the same cycle as a load is still searched, and it forwards if it is the youngest match.
- R6: An accepted load with no match pulses `mem_ld_valid` for one cycle, in the acceptance cycle, with `mem_ld_addr` equal to the load address. `cpu_rvalid` rises in the cycle `mem_resp_valid` is high, with `cpu_rdata` equal to `mem_resp_data`.
- R7: From the cycle after a load or swap is accepted up to and including the cycle `cpu_rvalid` is high, `cpu_ready` is low. In the cycle after `cpu_rvalid`, the port is open again.
- R8: A swap is queued with `mem_swap` high and its new data on `mem_wdata`. After it drains, the old value from memory arrives with `mem_resp_valid` and is passed to the processor with `cpu_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor presents an operation |
| cpu_op | input | 2 | 00 load, 10 swap, 01/11 store |
| cpu_addr | input | ADDR_W | Operation address |
| cpu_wdata | input | DATA_W | Store or swap data |
| cpu_ready | output | 1 | Operation accepted this cycle when valid |
| cpu_rvalid | output | 1 | Load or swap result valid |
| cpu_rdata | output | DATA_W | Load or swap result |
| mem_req | output | 1 | Oldest queued entry is offered to memory |
| mem_gnt | input | 1 | Memory takes the offered entry |
| mem_addr | output | ADDR_W | Address of oldest entry |
| mem_wdata | output | DATA_W | Data of oldest entry |
| mem_swap | output | 1 | Oldest entry is a swap |
| mem_ld_valid | output | 1 | Read request for a load that missed |
| mem_ld_addr | output | ADDR_W | Read request address |
| mem_resp_valid | input | 1 | Memory read or swap result valid |
| mem_resp_data | input | DATA_W | Memory read or swap result |

## Verification
A corrupted pointer or occupancy count shows up at the memory port on the very next cycle, as a wrong head address or data, or a request that rises or falls at the wrong time. It also shows at `cpu_ready`, which fails to drop at full or drops too early.

A wrong search shows in the cycle a load is accepted, as a spurious or missing read pulse. One cycle later it shows as stale forwarded data, such as an older entry winning over a younger one with the same address.

A stuck wait state shows as `cpu_ready` staying low after the result, or rising before it. The reference model compares every one of these outputs on every cycle, so each fault is caught within a cycle of its first visible effect.

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_swap,
  output logic              mem_ld_valid,
  output logic [ADDR_W-1:0] mem_ld_addr,
  input  logic              mem_resp_valid,
  input  logic [DATA_W-1:0] mem_resp_data
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_FWD, S_LDW, S_SWW} st_t;

  logic [ADDR_W-1:0] q_addr [DEPTH];
  logic [DATA_W-1:0] q_data [DEPTH];
  logic [DEPTH-1:0]  q_swap;
  logic [PW-1:0]     rd_ptr, wr_ptr, idx;
  logic [PW:0]       count;
  st_t               st;
  logic [DATA_W-1:0] fwd_q;
  logic              hit;
  logic [DATA_W-1:0] hit_data;

  wire is_load = (cpu_op == 2'b00);
  wire is_swap = (cpu_op == 2'b10);
  wire full    = (count == FULL_CNT);
  wire acc     = cpu_valid && cpu_ready;
  wire push    = acc && !is_load;
  wire pop     = mem_req && mem_gnt;

  assign cpu_ready    = (st == S_IDLE) && (is_load || !full);
  assign mem_req      = (count != '0);
  assign mem_addr     = q_addr[rd_ptr];
  assign mem_wdata    = q_data[rd_ptr];
  assign mem_swap     = q_swap[rd_ptr];
  assign mem_ld_valid = acc && is_load && !hit;
  assign mem_ld_addr  = cpu_addr;
  assign cpu_rvalid   = (st == S_FWD) || (((st == S_LDW) || (st == S_SWW)) && mem_resp_valid);
  assign cpu_rdata    = (st == S_FWD) ? fwd_q : mem_resp_data;

  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    idx      = rd_ptr;
    for (int i = 0; i < DEPTH; i++) begin
      idx = rd_ptr + PW'(i);
      if (((PW+1)'(i) < count) && (q_addr[idx] == cpu_addr)) begin
        hit      = 1'b1;
        hit_data = q_data[idx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[wr_ptr] <= cpu_addr;
      q_data[wr_ptr] <= cpu_wdata;
      q_swap[wr_ptr] <= is_swap;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      fwd_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (acc) begin
          if (is_load && hit) begin
            st    <= S_FWD;
            fwd_q <= hit_data;
          end else if (is_load) st <= S_LDW;
          else if (is_swap)     st <= S_SWW;
        end
        S_FWD:   st <= S_IDLE;
        default: if (mem_resp_valid) st <= S_IDLE;
      endcase
    end
  end
endmodule

module sfb_checker #(
  parameter int DEPTH = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_valid,
  input logic [1:0] cpu_op,
  input logic       cpu_ready,
  input logic       cpu_rvalid,
  input logic       mem_req,
  input logic       mem_gnt,
  input logic       mem_ld_valid,
  input logic       mem_swap
);
  int occ;
  wire c_push = cpu_valid && cpu_ready && (cpu_op != 2'b00);
  wire c_pop  = mem_req && mem_gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= 0;
    else occ <= occ + (c_push ? 1 : 0) - (c_pop ? 1 : 0);
  end

  a_r2_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == DEPTH && cpu_op != 2'b00) |-> !cpu_ready);
  a_r3_req_tracks_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req == (occ != 0));
  a_r3_head_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_swap)));
  a_r4_forward_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && cpu_op == 2'b00 && !mem_ld_valid) |=> cpu_rvalid);
  a_r6_read_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ld_valid |-> (cpu_valid && cpu_ready && cpu_op == 2'b00));
  a_r7_blocked_on_result: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> !cpu_ready);
  a_r7_blocked_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && (cpu_op == 2'b00 || cpu_op == 2'b10)) |=> !cpu_ready);
endmodule

bind store_fwd_buffer sfb_checker #(.DEPTH(DEPTH)) u_sfb_checker (.*);

// File: tb/tb_store_fwd_buffer.sv
module tb_store_fwd_buffer;
  localparam int DEPTH = 4;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic cpu_valid = 0;
  logic [1:0] cpu_op = 0;
  logic [AW-1:0] cpu_addr = 0;
  logic [DW-1:0] cpu_wdata = 0;
  logic cpu_ready, cpu_rvalid, mem_req, mem_swap, mem_ld_valid;
  logic [DW-1:0] cpu_rdata, mem_wdata;
  logic [AW-1:0] mem_addr, mem_ld_addr;
  logic mem_gnt = 0, mem_resp_valid = 0;
  logic [DW-1:0] mem_resp_data = 0;

  always #5 clk = ~clk;

  store_fwd_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) dut (.*);

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; logic sw; } ent_t;
  ent_t q[$];
  int st = 0;
  logic [DW-1:0] fwd_e = 0, resp_val = 0;
  logic [DW-1:0] mem_arr [8];
  int resp_cnt = 0;
  int checks = 0, errors = 0;
  bit started = 0, done = 0;
  int vpct = 80, lpct = 30, gpct = 50;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    bit h, is_load, is_swap, exp_ready, exp_req, acc, exp_ldv, exp_rv;
    logic [DW-1:0] hd;
    ent_t e;
    h = 0; hd = 0;
    foreach (q[i]) if (q[i].a == cpu_addr) begin h = 1; hd = q[i].d; end
    is_load = (cpu_op == 2'b00);
    is_swap = (cpu_op == 2'b10);
    exp_ready = (st == 0) && (is_load || q.size() < DEPTH);
    chk("R2 R7 cpu_ready", cpu_ready, exp_ready);
    exp_req = q.size() != 0;
    chk("R3 mem_req", mem_req, exp_req);
    if (exp_req) begin
      chk("R3 mem_addr", mem_addr, q[0].a);
      chk("R3 mem_wdata", mem_wdata, q[0].d);
      chk("R3 R8 mem_swap", mem_swap, q[0].sw);
    end
    acc = cpu_valid && exp_ready;
    exp_ldv = acc && is_load && !h;
    chk("R4 R5 R6 mem_ld_valid", mem_ld_valid, exp_ldv);
    if (exp_ldv) chk("R6 mem_ld_addr", mem_ld_addr, cpu_addr);
    exp_rv = (st == 1) || ((st == 2 || st == 3) && mem_resp_valid);
    chk("R4 R6 R8 cpu_rvalid", cpu_rvalid, exp_rv);
    if (exp_rv) chk("R4 R5 R6 R8 cpu_rdata", cpu_rdata, (st == 1) ? fwd_e : mem_resp_data);
    if (exp_rv) st = 0;
    if (mem_resp_valid) resp_cnt = 0;
    else if (resp_cnt > 1) resp_cnt--;
    if (acc && is_load) begin
      if (h) begin st = 1; fwd_e = hd; end
      else begin st = 2; resp_val = mem_arr[cpu_addr[2:0]]; resp_cnt = 1 + int'($urandom % 3); end
    end
    if (exp_req && mem_gnt) begin
      e = q.pop_front();
      if (e.sw) begin resp_val = mem_arr[e.a[2:0]]; resp_cnt = 1 + int'($urandom % 3); end
      mem_arr[e.a[2:0]] = e.d;
    end
    if (acc && !is_load) begin
      q.push_back('{a: cpu_addr, d: cpu_wdata, sw: is_swap});
      if (is_swap) st = 3;
    end
  end

  task automatic drive();
    int r;
    cpu_valid = ($urandom % 100) < vpct;
    r = int'($urandom % 100);
    if (r < lpct) cpu_op = 2'b00;
    else if (r < lpct + 8) cpu_op = 2'b10;
    else cpu_op = ($urandom % 2) ? 2'b01 : 2'b11;
    cpu_addr = AW'($urandom % 8);
    cpu_wdata = $urandom;
    mem_gnt = ($urandom % 100) < gpct;
    mem_resp_valid = (resp_cnt == 1);
    mem_resp_data = (resp_cnt == 1) ? resp_val : $urandom;
  endtask

  task automatic run(int n, int v, int l, int g);
    vpct = v; lpct = l; gpct = g;
    for (int c = 0; c < n; c++) begin
      @(posedge clk); #1; drive();
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mem_arr[i] = 32'h1000 + i;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 cpu_ready", cpu_ready, 1'b1);
    chk("R1 mem_req", mem_req, 1'b0);
    chk("R1 cpu_rvalid", cpu_rvalid, 1'b0);
    chk("R1 mem_ld_valid", mem_ld_valid, 1'b0);
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk("R1 mem_req after reset", mem_req, 1'b0);
    chk("R1 cpu_ready after reset", cpu_ready, 1'b1);
    started = 1;
    run(30, 100, 0, 0);
    run(40, 100, 100, 0);
    run(3000, 80, 30, 50);
    run(3000, 90, 60, 10);
    run(3000, 70, 20, 90);
    vpct = 0; gpct = 100;
    run(30, 0, 0, 100);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule